// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the automatic memory traffic around an interrupt for an 8-bit processor with a 16-bit program counter. An upstream arbiter hands it a one-cycle acceptance pulse and a source number. The sequencer then waits until the processor reports that its current instruction is done. Next it saves the return context on a downward-growing stack held in one fixed page. It reads the handler address for that source from a vector table and hands the processor a new program counter, a new status byte with the disable flag set, and the new stack pointer.

When the processor executes its return-from-interrupt instruction it raises a request. The sequencer then reads the three saved bytes back in the opposite order and hands the restored program counter, status and stack pointer to the core. During both sequences it drives a single-port byte memory bus, one transfer per cycle at most. A busy flag stays high for the whole time the sequence runs. Read data is expected one cycle after the read strobe.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry sequence does not start before a cycle in which `instrDone` is high. An acceptance that arrives while `instrDone` is low is held, and `busy` stays low until `instrDone` rises.
- R2: Entry writes three bytes, one per cycle, in this order: PC bits 15:8 at address {STACK_PAGE, sp}, PC bits 7:0 at {STACK_PAGE, sp-1}, then the status byte at {STACK_PAGE, sp-2}. Here sp is `curSp` and the arithmetic wraps modulo 256.
- R3: After the pushes, entry reads the vector low byte at VEC_BASE+2*src and then the high byte at VEC_BASE+2*src+1. `pcOut` is {high, low} in the cycle `pcLoad` is high.
- R4: When an acceptance is taken together with `instrDone`, `busy` is high for exactly 7 cycles. `pcLoad`, `psLoad` and `spLoad` pulse together in the 7th cycle.
- R5: At the end of entry, `spOut` equals sp-3 modulo 256.
- R6: The status byte pushed on entry is the unmodified `curPs`. The status loaded on entry is `curPs` with bit 2 (the disable flag) set.
- R7: A return reads {STACK_PAGE, sp+1} into status, then {STACK_PAGE, sp+2} into PC low and {STACK_PAGE, sp+3} into PC high. `busy` lasts 5 cycles, and the loads pulse in the 5th cycle with `spOut` = sp+3. After an entry, a return therefore restores the pre-entry PC and status.
- R8: If a return request meets an acceptance that is pending or new in the same idle cycle, the return runs first. The held source then enters once `instrDone` is next seen high.
- R9: An acceptance that arrives while a sequence is running is kept. It is serviced, with its own source, after that sequence ends.
- R10: `memWe` and `memRe` are never high together, and both are low whenever `busy` is low.
- R11: After reset, `busy`, `memWe`, `memRe`, `pcLoad`, `psLoad` and `spLoad` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acceptPulse | input | 1 | One-cycle pulse: an interrupt was accepted |
| srcIdx | input | SRC_W | Source number of the accepted interrupt |
| instrDone | input | 1 | Current instruction has completed |
| rtiReq | input | 1 | Return-from-interrupt instruction requests the pop sequence |
| curPc | input | 16 | Processor program counter |
| curPs | input | 8 | Processor status byte |
| curSp | input | 8 | Processor stack pointer |
| memRdata | input | 8 | Read data, valid the cycle after `memRe` |
| memAddr | output | 16 | Bus address |
| memWdata | output | 8 | Bus write data |
| memWe | output | 1 | Write enable |
| memRe | output | 1 | Read strobe |
| pcOut | output | 16 | New program counter |
| pcLoad | output | 1 | Load `pcOut` into the PC |
| psOut | output | 8 | New status byte |
| psLoad | output | 1 | Load `psOut` into the status register |
| spOut | output | 8 | New stack pointer |
| spLoad | output | 1 | Load `spOut` into the stack pointer |
| busy | output | 1 | A sequence is running |

## Verification
Two things can land in one cycle. An acceptance can coincide with a return request, and an acceptance can arrive while a sequence is already running. The bench provokes the first by holding an acceptance back with `instrDone` low and then raising `rtiReq` and `instrDone` together. It provokes the second by pulsing an acceptance in the middle of a return. In both cases the order of the load pulses is judged: the first load must carry the PC popped from the stack, and the second must carry the vector of the held source, with the stack pointer each sequence implies.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PUSH_H,
    OP_PUSH_L,
    OP_PUSH_P,
    OP_VEC_L,
    OP_VEC_H,
    OP_POP
  } busOp_e;

  typedef struct packed {
    logic   capture;
    busOp_e busOp;
    logic   latchLo;
    logic   latchPs;
    logic   finEntry;
    logic   finRet;
  } seqStrobe_t;

endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             acceptPulse,
  input  logic [SRC_W-1:0] srcIdx,
  input  logic             instrDone,
  input  logic             rtiReq,
  output seqStrobe_t       strobe,
  output logic [SRC_W-1:0] activeSrc,
  output logic             busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_ECAP, S_PH, S_PL, S_PP, S_VL, S_VH, S_EFIN,
    S_RCAP, S_QP, S_QL, S_QH, S_RFIN
  } seqState_e;

  seqState_e state, stateNxt;
  logic             pendValid;
  logic [SRC_W-1:0] pendSrc;
  logic [SRC_W-1:0] srcSel;
  logic             isIdle, startEntry, startRet;

  assign isIdle     = (state == S_IDLE);
  assign srcSel     = acceptPulse ? srcIdx : pendSrc;
  assign startEntry = isIdle && (acceptPulse || pendValid) && instrDone && !rtiReq;
  assign startRet   = isIdle && rtiReq;
  assign busy       = !isIdle;

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE:  if (startEntry) stateNxt = S_ECAP;
               else if (startRet) stateNxt = S_RCAP;
      S_ECAP:  stateNxt = S_PH;
      S_PH:    stateNxt = S_PL;
      S_PL:    stateNxt = S_PP;
      S_PP:    stateNxt = S_VL;
      S_VL:    stateNxt = S_VH;
      S_VH:    stateNxt = S_EFIN;
      S_RCAP:  stateNxt = S_QP;
      S_QP:    stateNxt = S_QL;
      S_QL:    stateNxt = S_QH;
      S_QH:    stateNxt = S_RFIN;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_comb begin
    strobe = '0;
    strobe.busOp = OP_NONE;
    case (state)
      S_ECAP, S_RCAP: strobe.capture = 1'b1;
      S_PH:   strobe.busOp = OP_PUSH_H;
      S_PL:   strobe.busOp = OP_PUSH_L;
      S_PP:   strobe.busOp = OP_PUSH_P;
      S_VL:   strobe.busOp = OP_VEC_L;
      S_VH:   begin strobe.busOp = OP_VEC_H; strobe.latchLo = 1'b1; end
      S_EFIN: strobe.finEntry = 1'b1;
      S_QP:   strobe.busOp = OP_POP;
      S_QL:   begin strobe.busOp = OP_POP; strobe.latchPs = 1'b1; end
      S_QH:   begin strobe.busOp = OP_POP; strobe.latchLo = 1'b1; end
      S_RFIN: strobe.finRet = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      pendValid <= 1'b0;
      pendSrc   <= '0;
      activeSrc <= '0;
    end else begin
      state <= stateNxt;
      if (startEntry) begin
        pendValid <= 1'b0;
        activeSrc <= srcSel;
      end else if (acceptPulse) begin
        pendValid <= 1'b1;
        pendSrc   <= srcIdx;
      end
    end
  end

  // R1: entry capture only follows a cycle with the instruction completed
  p_wait_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ECAP) |-> $past(instrDone));

  // R8: a return request in idle always wins over entry
  p_ret_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && rtiReq) |=> (state == S_RCAP));

  // R9: an acceptance during a running sequence is retained
  p_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && acceptPulse) |=> pendValid);

endmodule

// File: rtl/irq_seq_dp.sv
module irq_seq_dp
  import irq_seq_pkg::*;
#(
  parameter int          SRC_W      = 4,
  parameter logic [15:0] VEC_BASE   = 16'hFFE0,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter int          IFLAG_BIT  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [SRC_W-1:0] activeSrc,
  input  logic [15:0]      curPc,
  input  logic [7:0]       curPs,
  input  logic [7:0]       curSp,
  input  logic [7:0]       memRdata,
  output logic [15:0]      memAddr,
  output logic [7:0]       memWdata,
  output logic             memWe,
  output logic             memRe,
  output logic [15:0]      pcOut,
  output logic             pcLoad,
  output logic [7:0]       psOut,
  output logic             psLoad,
  output logic [7:0]       spOut,
  output logic             spLoad
);

  localparam int          PadW     = 15 - SRC_W;
  localparam logic [7:0]  FlagMask = 8'(1) << IFLAG_BIT;

  logic [15:0] pcSnap;
  logic [7:0]  psSnap, spSnap, workSp, loReg, psPop;
  logic [15:0] vecLoAddr;
  logic [7:0]  popSp;

  assign vecLoAddr = VEC_BASE + {{PadW{1'b0}}, activeSrc, 1'b0};
  assign popSp     = workSp + 8'd1;

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    memWe    = 1'b0;
    memRe    = 1'b0;
    case (strobe.busOp)
      OP_PUSH_H: begin memAddr = {STACK_PAGE, workSp}; memWdata = pcSnap[15:8]; memWe = 1'b1; end
      OP_PUSH_L: begin memAddr = {STACK_PAGE, workSp}; memWdata = pcSnap[7:0];  memWe = 1'b1; end
      OP_PUSH_P: begin memAddr = {STACK_PAGE, workSp}; memWdata = psSnap;       memWe = 1'b1; end
      OP_VEC_L:  begin memAddr = vecLoAddr;            memRe = 1'b1; end
      OP_VEC_H:  begin memAddr = vecLoAddr + 16'd1;    memRe = 1'b1; end
      OP_POP:    begin memAddr = {STACK_PAGE, popSp};  memRe = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcSnap <= '0;
      psSnap <= '0;
      spSnap <= '0;
      workSp <= '0;
      loReg  <= '0;
      psPop  <= '0;
    end else begin
      if (strobe.capture) begin
        pcSnap <= curPc;
        psSnap <= curPs;
        spSnap <= curSp;
        workSp <= curSp;
      end
      case (strobe.busOp)
        OP_PUSH_H, OP_PUSH_L, OP_PUSH_P: workSp <= workSp - 8'd1;
        OP_POP:                          workSp <= popSp;
        default: ;
      endcase
      if (strobe.latchLo) loReg <= memRdata;
      if (strobe.latchPs) psPop <= memRdata;
    end
  end

  assign pcOut  = {memRdata, loReg};
  assign pcLoad = strobe.finEntry | strobe.finRet;
  assign psLoad = pcLoad;
  assign spLoad = pcLoad;
  assign psOut  = strobe.finEntry ? (psSnap | FlagMask) : psPop;
  assign spOut  = workSp;

  // R2: successive pushes land on descending stack addresses
  p_push_descend_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busOp == OP_PUSH_L || strobe.busOp == OP_PUSH_P)
      |-> memAddr[7:0] == $past(memAddr[7:0]) - 8'd1);

  // R5: entry leaves the pointer three below its captured value
  p_sp_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finEntry |-> spOut == spSnap - 8'd3);

  // R7: return leaves the pointer three above its captured value
  p_sp_ret_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finRet |-> spOut == spSnap + 8'd3);

  // R10: one bus direction at a time
  p_bus_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          SRC_W      = 4,
  parameter logic [15:0] VEC_BASE   = 16'hFFE0,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter int          IFLAG_BIT  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             acceptPulse,
  input  logic [SRC_W-1:0] srcIdx,
  input  logic             instrDone,
  input  logic             rtiReq,
  input  logic [15:0]      curPc,
  input  logic [7:0]       curPs,
  input  logic [7:0]       curSp,
  input  logic [7:0]       memRdata,
  output logic [15:0]      memAddr,
  output logic [7:0]       memWdata,
  output logic             memWe,
  output logic             memRe,
  output logic [15:0]      pcOut,
  output logic             pcLoad,
  output logic [7:0]       psOut,
  output logic             psLoad,
  output logic [7:0]       spOut,
  output logic             spLoad,
  output logic             busy
);

  seqStrobe_t       strobe;
  logic [SRC_W-1:0] activeSrc;

  irq_seq_ctrl #(.SRC_W(SRC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .acceptPulse(acceptPulse), .srcIdx(srcIdx),
    .instrDone(instrDone), .rtiReq(rtiReq), .strobe(strobe),
    .activeSrc(activeSrc), .busy(busy)
  );

  irq_seq_dp #(
    .SRC_W(SRC_W), .VEC_BASE(VEC_BASE), .STACK_PAGE(STACK_PAGE), .IFLAG_BIT(IFLAG_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .activeSrc(activeSrc),
    .curPc(curPc), .curPs(curPs), .curSp(curSp), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .pcOut(pcOut), .pcLoad(pcLoad), .psOut(psOut), .psLoad(psLoad),
    .spOut(spOut), .spLoad(spLoad)
  );

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

  localparam int          ClkPeriod = 10;
  localparam logic [15:0] VecBase   = 16'hFFE0;
  localparam logic [7:0]  StkPage   = 8'h01;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic acceptPulse = 1'b0, instrDone = 1'b0, rtiReq = 1'b0;
  logic [3:0]  srcIdx = '0;
  logic [15:0] curPc = '0;
  logic [7:0]  curPs = '0, curSp = '0, memRdata = '0;
  logic [15:0] memAddr, pcOut;
  logic [7:0]  memWdata, psOut, spOut;
  logic memWe, memRe, pcLoad, psLoad, spLoad, busy;

  int checks = 0, failures = 0, busErr = 0;
  logic [7:0]  stackMem [256];
  logic [15:0] wAddr [8]; logic [7:0] wData [8]; int wCnt;
  logic [15:0] rAddr [8]; int rCnt;
  logic [15:0] ldPc [4]; logic [7:0] ldPs [4], ldSp [4]; int ldAt [4]; int ldCnt;
  int busyCnt;

  always #(ClkPeriod/2) clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rstN(rstN), .acceptPulse(acceptPulse), .srcIdx(srcIdx),
    .instrDone(instrDone), .rtiReq(rtiReq), .curPc(curPc), .curPs(curPs),
    .curSp(curSp), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRe(memRe), .pcOut(pcOut), .pcLoad(pcLoad),
    .psOut(psOut), .psLoad(psLoad), .spOut(spOut), .spLoad(spLoad), .busy(busy)
  );

  function automatic logic [7:0] vecByte(input int j);
    return 8'((j * 29) ^ 165);
  endfunction

  function automatic logic [15:0] expVec(input int s);
    return {vecByte(2 * s + 1), vecByte(2 * s)};
  endfunction

  function automatic logic [7:0] rdByte(input logic [15:0] a);
    if (a[15:8] == StkPage) return stackMem[a[7:0]];
    if (a >= VecBase) return vecByte(int'(a - VecBase));
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (memWe) stackMem[memAddr[7:0]] <= memWdata;
    if (memRe) memRdata <= rdByte(memAddr);
  end

  always @(negedge clk) begin
    if (rstN) begin
      if ((memWe && memRe) || (!busy && (memWe || memRe))) busErr++;
      if (busy) busyCnt++;
      if (memWe && wCnt < 8) begin wAddr[wCnt] = memAddr; wData[wCnt] = memWdata; wCnt++; end
      if (memRe && rCnt < 8) begin rAddr[rCnt] = memAddr; rCnt++; end
      if (pcLoad && ldCnt < 4) begin
        ldPc[ldCnt] = pcOut; ldPs[ldCnt] = psOut; ldSp[ldCnt] = spOut;
        ldAt[ldCnt] = busyCnt; ldCnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic clearLog();
    wCnt = 0; rCnt = 0; ldCnt = 0; busyCnt = 0;
  endtask

  task automatic waitIdle();
    int g = 0;
    do begin @(negedge clk); g++; end while (busy && g < 40);
    chk(g < 40, "sequence never ended", g, 40);
  endtask

  task automatic runEntry(input int src, input logic [15:0] pc, input logic [7:0] ps,
                          input logic [7:0] sp, input int waitN);
    clearLog();
    curPc = pc; curPs = ps; curSp = sp;
    @(negedge clk); acceptPulse = 1'b1; srcIdx = 4'(src); instrDone = (waitN == 0);
    for (int k = 0; k < waitN; k++) begin
      @(negedge clk); acceptPulse = 1'b0;
      chk(busy == 1'b0, "R1 busy before instrDone", busy, 0);
      if (k == waitN - 1) instrDone = 1'b1;
    end
    @(negedge clk); acceptPulse = 1'b0; instrDone = 1'b0;
    waitIdle();
    chk(busyCnt == 7 && ldCnt == 1 && ldAt[0] == 7, "R4 entry length/load cycle", busyCnt * 16 + ldAt[0], 7 * 16 + 7);
    chk(wCnt == 3, "R2 push count", wCnt, 3);
    chk(wAddr[0] == {StkPage, sp} && wData[0] == pc[15:8], "R2 push PC high", {wAddr[0], wData[0]}, {StkPage, sp, pc[15:8]});
    chk(wAddr[1] == {StkPage, 8'(sp - 8'd1)} && wData[1] == pc[7:0], "R2 push PC low", {wAddr[1], wData[1]}, {StkPage, 8'(sp - 8'd1), pc[7:0]});
    chk(wAddr[2] == {StkPage, 8'(sp - 8'd2)}, "R2 push status addr", wAddr[2], {StkPage, 8'(sp - 8'd2)});
    chk(wData[2] == ps, "R6 pushed status", wData[2], ps);
    chk(rCnt == 2 && rAddr[0] == VecBase + 16'(2 * src) && rAddr[1] == VecBase + 16'(2 * src + 1),
        "R3 vector addresses", {rAddr[0], rAddr[1]}, {VecBase + 16'(2 * src), VecBase + 16'(2 * src + 1)});
    chk(ldPc[0] == expVec(src), "R3 handler PC", ldPc[0], expVec(src));
    chk(ldPs[0] == (ps | 8'h04), "R6 loaded status", ldPs[0], ps | 8'h04);
    chk(ldSp[0] == 8'(sp - 8'd3), "R5 entry sp", ldSp[0], 8'(sp - 8'd3));
  endtask

  task automatic runReturn(input logic [7:0] sp, input logic [15:0] pc, input logic [7:0] ps);
    clearLog();
    curSp = sp;
    @(negedge clk); rtiReq = 1'b1;
    @(negedge clk); rtiReq = 1'b0;
    waitIdle();
    chk(busyCnt == 5 && ldCnt == 1 && ldAt[0] == 5, "R7 return length/load cycle", busyCnt * 16 + ldAt[0], 5 * 16 + 5);
    chk(wCnt == 0 && rCnt == 3 && rAddr[0] == {StkPage, 8'(sp + 8'd1)} && rAddr[1] == {StkPage, 8'(sp + 8'd2)}
        && rAddr[2] == {StkPage, 8'(sp + 8'd3)}, "R7 pop order", rAddr[0], {StkPage, 8'(sp + 8'd1)});
    chk(ldPc[0] == pc && ldPs[0] == ps, "R7 restored PC/status", {ldPc[0], ldPs[0]}, {pc, ps});
    chk(ldSp[0] == 8'(sp + 8'd3), "R7 return sp", ldSp[0], 8'(sp + 8'd3));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) stackMem[i] = 8'(i ^ 8'h5A);
    clearLog();
    repeat (3) @(negedge clk);
    chk(!busy && !memWe && !memRe && !pcLoad && !psLoad && !spLoad, "R11 reset outputs",
        {busy, memWe, memRe, pcLoad, psLoad, spLoad}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !pcLoad, "R11 idle after reset", {busy, pcLoad}, 0);

    // directed corners: stack wrap, extreme sources, longest wait
    runEntry(0, 16'h1234, 8'h00, 8'h01, 0);
    runReturn(8'hFE, 16'h1234, 8'h00);
    runEntry(15, 16'hBEEF, 8'hFB, 8'h00, 16);
    runReturn(8'hFD, 16'hBEEF, 8'hFB);

    // random entry/return round trips
    for (int i = 0; i < 40; i++) begin
      int s = int'($urandom % 16);
      logic [15:0] pc = 16'($urandom);
      logic [7:0] ps = 8'($urandom);
      logic [7:0] sp = 8'($urandom);
      int w = int'($urandom % 17);
      runEntry(s, pc, ps, sp, w);
      runReturn(8'(sp - 8'd3), pc, ps);
    end

    // R8: return request meets a held acceptance in the same idle cycle
    clearLog();
    curSp = 8'h80; stackMem[8'h81] = 8'h33; stackMem[8'h82] = 8'hCD; stackMem[8'h83] = 8'hAB;
    @(negedge clk); acceptPulse = 1'b1; srcIdx = 4'd9; instrDone = 1'b0;
    @(negedge clk); acceptPulse = 1'b0; rtiReq = 1'b1; instrDone = 1'b1;
    @(negedge clk); rtiReq = 1'b0; instrDone = 1'b0;
    waitIdle();
    @(negedge clk); instrDone = 1'b1;
    @(negedge clk); instrDone = 1'b0;
    waitIdle();
    chk(ldCnt == 2 && ldPc[0] == 16'hABCD && ldPs[0] == 8'h33, "R8 return served first", ldPc[0], 16'hABCD);
    chk(ldPc[1] == expVec(9) && ldSp[1] == 8'h7D, "R8 held entry after return", ldPc[1], expVec(9));

    // R9: acceptance arrives in the middle of a return
    clearLog();
    curSp = 8'h40; stackMem[8'h41] = 8'h11; stackMem[8'h42] = 8'h22; stackMem[8'h43] = 8'h44;
    @(negedge clk); rtiReq = 1'b1;
    @(negedge clk); rtiReq = 1'b0;
    @(negedge clk); acceptPulse = 1'b1; srcIdx = 4'd5;
    @(negedge clk); acceptPulse = 1'b0;
    waitIdle();
    chk(ldCnt == 1 && ldPc[0] == 16'h4422, "R9 return unaffected", ldPc[0], 16'h4422);
    @(negedge clk); instrDone = 1'b1;
    @(negedge clk); instrDone = 1'b0;
    waitIdle();
    chk(ldCnt == 2 && ldPc[1] == expVec(5), "R9 held source serviced", ldPc[1], expVec(5));

    chk(busErr == 0, "R10 bus exclusivity/idle", busErr, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule